// File: doc/BRIEF.md
# Domain-Mapped Supply Fault Responder

This controller sits inside a safety power-management device, between the digital outputs of the supply monitors and the pins that hold the processor in a safe state. It receives one fault level per output rail (undervoltage or overvoltage), one fault level for the input power-good monitor and one fault level for input overvoltage. Each source is tied to one of three severity classes: MCU, SoC or other. The class decides how the controller responds. An MCU-class fault powers everything down. An SoC-class fault resets and unpowers only the SoC. An other-class fault only raises an interrupt.

Every fault is latched into a sticky flag that survives a shutdown and restart. The flags stay readable, and are cleared, through a small register port. The controller also compares the levels read back from its safety pins with the levels it commands, and it reports any difference as a fault of its own. A short fault pulse below a programmable length is filtered out. An input overvoltage skips the filter and opens the input switch on the next clock edge.

Top module: `supply_fault_responder`

## Requirements
- R1: Register 0 holds the class map: 2 bits per source, with source i in bits [2i+1:2i]. Rails 0 to 5 use sources 0 to 5, and the input power-good monitor uses source 6 (bits [13:12]). Code 0 means MCU, 1 means SoC, and 2 or 3 mean other. The reset value is 0, so every source is MCU class.
- R2: An accepted MCU-class fault drives the following, one edge after acceptance: endrv low, mcu_rst_n low, soc_rst_n low and every rail_en bit low. It also sets flag bit 0. While the block is shut down, int_n stays high.
- R3: A one-cycle wake_req pulse during shutdown returns the block to running. All rails are enabled, both resets are released and the input switch is closed. The flags are kept, so int_n goes low if any flag is set.
- R4: An accepted SoC-class fault drives soc_rst_n low, disables only the rails mapped to SoC, keeps endrv and mcu_rst_n high, sets flag bit 1 and drives int_n low. A wake_req pulse while running brings the SoC back.
- R5: An accepted other-class rail fault sets flag bit 2 and drives int_n low. It leaves every rail enabled and both resets released.
- R6: When faults of several classes are accepted in the same cycle, the most severe response is applied, in the order MCU, SoC, other. Every matching flag is set.
- R7: vin_ov while running is acted on with no filtering. One edge later vin_sw_on and endrv are low, the block is fully shut down and flag bit 3 is set.
- R8: Register 1 bit 8 enables the input power-good fault. When it is set, that fault is filtered and then handled according to the class in source 6, and it sets flag bit 4 (not bits 0 to 2). When it is clear, the fault is ignored.
- R9: Register 1 bits [3:0] hold L, with a reset value of 2. A rail or power-good fault is accepted only once it has been high on L+1 consecutive clock edges.
- R10: Register 2 holds the sticky flags [5:0]. Writing 1 to a bit clears it, and writing 0 has no effect. int_n is high while running exactly when all flags are clear.
- R11: Writes to registers 0 and 1 are ignored unless all of these hold: the block is running, the SoC is not held down, and no fault input is being filtered.
- R12: If endrv_fb, mcu_rst_fb, soc_rst_fb or int_fb differs from the level the block commands on the matching pin, flag bit 5 is set and int_n goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| rail_flt | input | 6 | Per-rail fault level (UV or OV) |
| vin_pg_flt | input | 1 | Input power-good fault level |
| vin_ov | input | 1 | Input overvoltage level |
| wake_req | input | 1 | Restart request pulse |
| endrv_fb | input | 1 | Read-back of endrv pin |
| mcu_rst_fb | input | 1 | Read-back of mcu_rst_n pin |
| soc_rst_fb | input | 1 | Read-back of soc_rst_n pin |
| int_fb | input | 1 | Read-back of int_n pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| endrv | output | 1 | Safety enable drive, high when safe to actuate |
| mcu_rst_n | output | 1 | MCU reset, active low |
| soc_rst_n | output | 1 | SoC reset, active low |
| rail_en | output | 6 | Per-rail enable |
| vin_sw_on | output | 1 | External input switch closed |
| int_n | output | 1 | Interrupt, active low |

## Verification
The bench targets the following corner cases:
- Mixed-class faults in one cycle. A design with the wrong priority would leave the MCU powered when an SoC fault masks a simultaneous MCU fault.
- Fault pulses exactly L and L+1 edges long. An off-by-one in the filter either accepts a glitch or misses a real fault.
- Flags across a shutdown and restart. A design that clears them on shutdown loses the report the MCU needs at restart.
- Configuration writes during an SoC hold-down, the power-good fault with its enable off, and a single injected read-back mismatch. Each of these shows up as a changed register value or a missing flag.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam logic [1:0] DOM_MCU = 2'd0;
  localparam logic [1:0] DOM_SOC = 2'd1;

  localparam int FLAG_MCU = 0;
  localparam int FLAG_SOC = 1;
  localparam int FLAG_OTH = 2;
  localparam int FLAG_VOV = 3;
  localparam int FLAG_PG  = 4;
  localparam int FLAG_RB  = 5;
  localparam int NUM_FLAGS = 6;

  localparam logic [1:0] ADDR_MAP  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  function automatic logic code_is_mcu(logic [1:0] c);
    return c == DOM_MCU;
  endfunction

  function automatic logic code_is_soc(logic [1:0] c);
    return c == DOM_SOC;
  endfunction

  function automatic logic code_is_oth(logic [1:0] c);
    return c[1];
  endfunction
endpackage

// File: rtl/sfr_glitch_filter.sv
module sfr_glitch_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          din,
  input  logic [FW-1:0] len,
  output logic          busy,
  output logic          pass
);
  localparam logic [FW-1:0] CNT_MAX = '1;
  logic [FW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!en || !din)    cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign busy = en && din;
  assign pass = en && din && (cnt >= len);
endmodule

// File: rtl/sfr_domain_resolver.sv
module sfr_domain_resolver #(
  parameter int N_RAILS = 6,
  localparam int MAP_W = 2 * (N_RAILS + 1)
) (
  input  logic [N_RAILS-1:0] rail_pass,
  input  logic               pg_pass,
  input  logic [MAP_W-1:0]   map,
  output logic               fl_mcu,
  output logic               fl_soc,
  output logic               fl_oth,
  output logic               resp_mcu,
  output logic               resp_soc
);
  import sfr_pkg::*;
  logic [N_RAILS-1:0] hit_m, hit_s, hit_o;
  logic [1:0] pg_code;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_slot
    logic [1:0] code;
    assign code     = map[2*i +: 2];
    assign hit_m[i] = rail_pass[i] && code_is_mcu(code);
    assign hit_s[i] = rail_pass[i] && code_is_soc(code);
    assign hit_o[i] = rail_pass[i] && code_is_oth(code);
  end

  assign pg_code  = map[2*N_RAILS +: 2];
  assign fl_mcu   = |hit_m;
  assign fl_soc   = |hit_s;
  assign fl_oth   = |hit_o;
  assign resp_mcu = fl_mcu || (pg_pass && code_is_mcu(pg_code));
  assign resp_soc = fl_soc || (pg_pass && code_is_soc(pg_code));
endmodule

// File: rtl/sfr_sequencer.sv
module sfr_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic resp_mcu,
  input  logic resp_soc,
  input  logic vin_ov,
  input  logic wake_req,
  output logic running,
  output logic soc_down,
  output logic vin_cut
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b1;
      soc_down <= 1'b0;
      vin_cut  <= 1'b0;
    end else if (running) begin
      if (vin_ov || resp_mcu) begin
        running  <= 1'b0;
        soc_down <= 1'b0;
        vin_cut  <= vin_ov;
      end else if (resp_soc) begin
        soc_down <= 1'b1;
      end else if (wake_req) begin
        soc_down <= 1'b0;
      end
    end else if (wake_req) begin
      running  <= 1'b1;
      soc_down <= 1'b0;
      vin_cut  <= 1'b0;
    end
  end
endmodule

// File: rtl/supply_fault_responder.sv
module supply_fault_responder #(
  parameter int N_RAILS = 6,
  parameter int FW = 4,
  parameter int REG_W = 16,
  parameter logic [FW-1:0] FILT_DEF = 4'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] rail_flt,
  input  logic               vin_pg_flt,
  input  logic               vin_ov,
  input  logic               wake_req,
  input  logic               endrv_fb,
  input  logic               mcu_rst_fb,
  input  logic               soc_rst_fb,
  input  logic               int_fb,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               endrv,
  output logic               mcu_rst_n,
  output logic               soc_rst_n,
  output logic [N_RAILS-1:0] rail_en,
  output logic               vin_sw_on,
  output logic               int_n
);
  import sfr_pkg::*;
  localparam int MAP_W  = 2 * (N_RAILS + 1);
  localparam int PG_BIT = 8;
  localparam int NF     = NUM_FLAGS;

  logic [MAP_W-1:0]   map_q;
  logic [FW-1:0]      len_q;
  logic               pg_en_q;
  logic [NF-1:0]      flags_q, flag_set, clr_mask;
  logic [N_RAILS-1:0] rail_pass, rail_busy;
  logic               pg_pass, pg_busy;
  logic               fl_mcu, fl_soc, fl_oth, resp_mcu, resp_soc;
  logic               running, soc_down, vin_cut;
  logic               vin_ov_acc, rb_err, cfg_ok;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    sfr_glitch_filter #(.FW(FW)) u_filt (
      .clk(clk), .rst_n(rst_n), .en(rail_en[i]), .din(rail_flt[i]),
      .len(len_q), .busy(rail_busy[i]), .pass(rail_pass[i]));
    assign rail_en[i] = running &&
                        !(soc_down && code_is_soc(map_q[2*i +: 2]));
  end

  sfr_glitch_filter #(.FW(FW)) u_pg_filt (
    .clk(clk), .rst_n(rst_n), .en(running && pg_en_q), .din(vin_pg_flt),
    .len(len_q), .busy(pg_busy), .pass(pg_pass));

  sfr_domain_resolver #(.N_RAILS(N_RAILS)) u_res (
    .rail_pass(rail_pass), .pg_pass(pg_pass), .map(map_q),
    .fl_mcu(fl_mcu), .fl_soc(fl_soc), .fl_oth(fl_oth),
    .resp_mcu(resp_mcu), .resp_soc(resp_soc));

  assign vin_ov_acc = running && vin_ov;

  sfr_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .resp_mcu(resp_mcu), .resp_soc(resp_soc),
    .vin_ov(vin_ov_acc), .wake_req(wake_req),
    .running(running), .soc_down(soc_down), .vin_cut(vin_cut));

  assign endrv     = running;
  assign mcu_rst_n = running;
  assign soc_rst_n = running && !soc_down;
  assign vin_sw_on = !vin_cut;
  assign int_n     = !(running && (|flags_q));

  assign rb_err = (endrv_fb != endrv) || (mcu_rst_fb != mcu_rst_n) ||
                  (soc_rst_fb != soc_rst_n) || (int_fb != int_n);

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_MCU] = fl_mcu;
    flag_set[FLAG_SOC] = fl_soc;
    flag_set[FLAG_OTH] = fl_oth;
    flag_set[FLAG_VOV] = vin_ov_acc;
    flag_set[FLAG_PG]  = pg_pass;
    flag_set[FLAG_RB]  = rb_err;
  end

  assign clr_mask = (reg_wr && reg_addr == ADDR_FLAG) ? reg_wdata[NF-1:0] : '0;
  assign cfg_ok   = running && !soc_down && !(|rail_busy) && !pg_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q   <= '0;
      len_q   <= FILT_DEF;
      pg_en_q <= 1'b0;
      flags_q <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | flag_set;
      if (reg_wr && cfg_ok && reg_addr == ADDR_MAP)
        map_q <= reg_wdata[MAP_W-1:0];
      if (reg_wr && cfg_ok && reg_addr == ADDR_CTRL) begin
        len_q   <= reg_wdata[FW-1:0];
        pg_en_q <= reg_wdata[PG_BIT];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_MAP:  reg_rdata[MAP_W-1:0] = map_q;
      ADDR_CTRL: begin
        reg_rdata[FW-1:0]  = len_q;
        reg_rdata[PG_BIT]  = pg_en_q;
      end
      ADDR_FLAG: reg_rdata[NF-1:0] = flags_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int N_RAILS = 6,
  parameter int NF = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               running,
  input logic               soc_down,
  input logic               resp_mcu,
  input logic               resp_soc,
  input logic               vin_ov_acc,
  input logic               wake_req,
  input logic               endrv,
  input logic               mcu_rst_n,
  input logic               soc_rst_n,
  input logic               int_n,
  input logic               vin_sw_on,
  input logic [N_RAILS-1:0] rail_en,
  input logic [NF-1:0]      flags_q,
  input logic [NF-1:0]      clr_mask
);
  p_mcu_shutdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running && resp_mcu |=> !endrv && !mcu_rst_n && !soc_rst_n && rail_en == '0);

  p_soc_keeps_mcu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running && resp_soc && !resp_mcu && !vin_ov_acc
    |=> endrv && mcu_rst_n && !soc_rst_n);

  p_other_no_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running && !soc_down && !resp_mcu && !resp_soc && !vin_ov_acc && !wake_req
    |=> mcu_rst_n && soc_rst_n && $countones(rail_en) == N_RAILS);

  p_vin_ov_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vin_ov_acc |=> !vin_sw_on && !endrv);

  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr_mask)) == $past(flags_q & ~clr_mask)));

  p_shutdown_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> int_n);
endmodule

bind supply_fault_responder sfr_checker #(.N_RAILS(N_RAILS), .NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .soc_down(soc_down),
  .resp_mcu(resp_mcu), .resp_soc(resp_soc), .vin_ov_acc(vin_ov_acc),
  .wake_req(wake_req), .endrv(endrv), .mcu_rst_n(mcu_rst_n),
  .soc_rst_n(soc_rst_n), .int_n(int_n), .vin_sw_on(vin_sw_on),
  .rail_en(rail_en), .flags_q(flags_q), .clr_mask(clr_mask));

// File: tb/supply_fault_responder_test.sv
module supply_fault_responder_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] rail_flt = '0;
  logic vin_pg_flt = 1'b0, vin_ov = 1'b0, wake_req = 1'b0;
  logic [3:0] inj = '0;
  logic endrv_fb, mcu_rst_fb, soc_rst_fb, int_fb;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic endrv, mcu_rst_n, soc_rst_n, vin_sw_on, int_n;
  logic [5:0] rail_en;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign endrv_fb   = endrv ^ inj[0];
  assign mcu_rst_fb = mcu_rst_n ^ inj[1];
  assign soc_rst_fb = soc_rst_n ^ inj[2];
  assign int_fb     = int_n ^ inj[3];

  supply_fault_responder uut (
    .clk(clk), .rst_n(rst_n), .rail_flt(rail_flt), .vin_pg_flt(vin_pg_flt),
    .vin_ov(vin_ov), .wake_req(wake_req), .endrv_fb(endrv_fb),
    .mcu_rst_fb(mcu_rst_fb), .soc_rst_fb(soc_rst_fb), .int_fb(int_fb),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .endrv(endrv), .mcu_rst_n(mcu_rst_n),
    .soc_rst_n(soc_rst_n), .rail_en(rail_en), .vin_sw_on(vin_sw_on),
    .int_n(int_n));

  typedef struct packed {
    logic [15:0] map;
    logic [5:0]  flt;
    logic        e_endrv, e_mcu, e_soc, e_int;
    logic [5:0]  e_rails;
    logic [5:0]  e_flags;
  } vec_t;

  // map 0x0A50: rails 0,1 MCU; 2,3 SoC; 4,5 other
  localparam vec_t VT [9] = '{
    '{16'h0A50, 6'b000001, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b000001},
    '{16'h0A50, 6'b000100, 1'b1, 1'b1, 1'b0, 1'b0, 6'b110011, 6'b000010},
    '{16'h0A50, 6'b010000, 1'b1, 1'b1, 1'b1, 1'b0, 6'b111111, 6'b000100},
    '{16'h0A50, 6'b100100, 1'b1, 1'b1, 1'b0, 1'b0, 6'b110011, 6'b000110},
    '{16'h0A50, 6'b000101, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b000011},
    '{16'h0A50, 6'b111111, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b000111},
    '{16'h0000, 6'b100000, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b000001},
    '{16'h0555, 6'b001000, 1'b1, 1'b1, 1'b0, 1'b0, 6'b000000, 6'b000010},
    '{16'h0A50, 6'b000000, 1'b1, 1'b1, 1'b1, 1'b1, 6'b111111, 6'b000000}
  };

  task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rail_flt = '0; vin_pg_flt = 0; vin_ov = 0; wake_req = 0; inj = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic reg_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic hold_fault(logic [5:0] f, int cycles);
    @(negedge clk);
    rail_flt = f;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    rail_flt = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    // reset state (R1, R10, R9)
    do_reset();
    check("R2", "endrv reset", {15'd0, endrv}, 16'd1);
    check("R2", "resets released", {14'd0, mcu_rst_n, soc_rst_n}, 16'd3);
    check("R4", "rails on", {10'd0, rail_en}, 16'h3F);
    check("R7", "switch closed", {15'd0, vin_sw_on}, 16'd1);
    check("R10", "int idle", {15'd0, int_n}, 16'd1);
    reg_read(2'd0, rd); check("R1", "map default", rd, 16'h0000);
    reg_read(2'd1, rd); check("R9", "ctrl default", rd, 16'h0002);

    // table walk: R2 R4 R5 R6
    foreach (VT[k]) begin
      do_reset();
      reg_write(2'd0, VT[k].map);
      hold_fault(VT[k].flt, 4);
      check("R6", $sformatf("v%0d endrv", k), {15'd0, endrv}, {15'd0, VT[k].e_endrv});
      check("R2", $sformatf("v%0d mcu_rst_n", k), {15'd0, mcu_rst_n}, {15'd0, VT[k].e_mcu});
      check("R4", $sformatf("v%0d soc_rst_n", k), {15'd0, soc_rst_n}, {15'd0, VT[k].e_soc});
      check("R5", $sformatf("v%0d int_n", k), {15'd0, int_n}, {15'd0, VT[k].e_int});
      check("R4", $sformatf("v%0d rails", k), {10'd0, rail_en}, {10'd0, VT[k].e_rails});
      reg_read(2'd2, rd);
      check("R6", $sformatf("v%0d flags", k), rd, {10'd0, VT[k].e_flags});
    end

    // R3 + R10: flags survive shutdown, restart reports, W1C
    do_reset();
    reg_write(2'd0, 16'h0A50);
    hold_fault(6'b000010, 4);
    check("R2", "int high while off", {15'd0, int_n}, 16'd1);
    pulse_wake();
    check("R3", "restart rails", {10'd0, rail_en}, 16'h3F);
    check("R3", "restart endrv", {15'd0, endrv}, 16'd1);
    check("R3", "int after restart", {15'd0, int_n}, 16'd0);
    reg_read(2'd2, rd); check("R3", "flag kept", rd, 16'h0001);
    reg_write(2'd2, 16'h0000);
    reg_read(2'd2, rd); check("R10", "write 0 keeps", rd, 16'h0001);
    reg_write(2'd2, 16'h0001);
    reg_read(2'd2, rd); check("R10", "w1c clears", rd, 16'h0000);
    check("R10", "int released", {15'd0, int_n}, 16'd1);

    // R11: config locked while SoC held down, R4 wake release
    hold_fault(6'b001000, 4);
    reg_write(2'd0, 16'h0000);
    reg_read(2'd0, rd); check("R11", "map locked", rd, 16'h0A50);
    pulse_wake();
    check("R4", "soc released", {15'd0, soc_rst_n}, 16'd1);
    check("R4", "soc rails back", {10'd0, rail_en}, 16'h3F);

    // R9: filter boundary with L=3
    do_reset();
    reg_write(2'd0, 16'h0A50);
    reg_write(2'd1, 16'h0003);
    hold_fault(6'b010000, 3);
    reg_read(2'd2, rd); check("R9", "L edges rejected", rd, 16'h0000);
    hold_fault(6'b010000, 4);
    reg_read(2'd2, rd); check("R9", "L+1 edges accepted", rd, 16'h0004);

    // R7: input overvoltage, one edge, no filter
    do_reset();
    @(negedge clk); vin_ov = 1'b1;
    @(negedge clk); vin_ov = 1'b0;
    check("R7", "switch opened", {15'd0, vin_sw_on}, 16'd0);
    check("R7", "endrv low", {15'd0, endrv}, 16'd0);
    check("R7", "rails off", {10'd0, rail_en}, 16'h00);
    pulse_wake();
    check("R7", "switch reclosed", {15'd0, vin_sw_on}, 16'd1);
    reg_read(2'd2, rd); check("R7", "vin ov flag", rd, 16'h0008);

    // R8: power-good fault ignored when disabled, SoC-class when enabled
    do_reset();
    reg_write(2'd0, 16'h1A50);
    @(negedge clk); vin_pg_flt = 1'b1;
    repeat (5) @(negedge clk); vin_pg_flt = 1'b0;
    @(negedge clk);
    reg_read(2'd2, rd); check("R8", "pg ignored", rd, 16'h0000);
    check("R8", "pg ignored rails", {10'd0, rail_en}, 16'h3F);
    reg_write(2'd1, 16'h0102);
    @(negedge clk); vin_pg_flt = 1'b1;
    repeat (5) @(negedge clk); vin_pg_flt = 1'b0;
    @(negedge clk);
    reg_read(2'd2, rd); check("R8", "pg flag", rd, 16'h0010);
    check("R8", "pg soc reset", {14'd0, mcu_rst_n, soc_rst_n}, 16'd2);
    check("R8", "pg soc rails", {10'd0, rail_en}, 16'h33);

    // R12: read-back mismatch
    do_reset();
    @(negedge clk); inj = 4'b0100;
    @(negedge clk); inj = 4'b0000;
    @(negedge clk);
    reg_read(2'd2, rd); check("R12", "readback flag", rd, 16'h0020);
    check("R12", "readback int", {15'd0, int_n}, 16'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule